// File: doc/BRIEF.md
# SM3 Iterative Compression Engine

This block runs the 64-round SM3 compression function on a single 512-bit message block. It executes one round per clock. The caller supplies the 256-bit chaining value. An external expander delivers one pair of per-round message words each round: the plain word W_j and the mixed word W'_j = W_j XOR W_(j+4). When the 64th round has been applied, the engine folds its working state back into the saved chaining value with XOR. It presents the result on `cv_out` together with a one-cycle `done` pulse. Padding, length encoding, multi-block sequencing and message expansion belong to the surrounding logic.

Control is a three-state machine:
- **IDLE**: waits for `start`. `start` moves it to ROUND and, on the same edge, loads the working and saved chaining registers from `cv_in` and clears the round counter.
- **ROUND**: raises `msg_ready`. Each edge with `msg_valid` high applies one round and advances the counter. The handshake for round 63 moves it to FOLD.
- **FOLD**: registers the XOR feed-forward into `cv_out`, raises `done` for the next cycle, and returns unconditionally to IDLE.

Chaining words are packed with word A in bits 255:224 and word H in bits 31:0. Both rotating constants and the boolean-function switch at round 16 are derived from the round counter.

Top module: `sm3c_engine`

## Requirements
- R1: While reset is active and on the first cycle after it, `busy`, `done` and `msg_ready` are 0, and `cv_out` is all zeros.
- R2: A `start` sampled high in IDLE makes `busy` and `msg_ready` read 1 from the next cycle, with `round_idx` at 0. `msg_ready` is never 1 while `busy` is 0.
- R3: `done` is high for exactly one cycle. That cycle begins at the second rising edge after the 64th message-word handshake, and `busy` is 0 in it.
- R4: A cycle in ROUND with `msg_valid` low applies no round and leaves `round_idx` unchanged. The final result does not depend on how many such stall cycles occur or where they fall.
- R5: `start` is ignored while `busy` is 1: the run in progress continues and its result is unchanged.
- R6: With chaining input 7380166f 4914b2b9 172442d7 da8a0600 a96f30bc 163138aa e38dee4d b0fb0e4e and the padded block for "abc" (word 0 = 61626380, words 1..14 = 0, word 15 = 00000018), `cv_out` reads 66c7f0f4 62eeedd9 d1f2d46b dc10e4e2 4167c487 5cf2f7a2 297da02b 8f4ba8e0.
- R7: For any block, `cv_out` equals the SM3 compression of the input. This uses K_j = rol(T, j mod 32), with T = 79cc4519 for j < 16 and 7a879d8a otherwise. Rounds 0..15 use XOR for both boolean functions; later rounds use majority and the select function.
- R8: The chaining value used for the final XOR is the one present on `cv_in` when `start` was accepted. Changes to `cv_in` while busy have no effect.
- R9: `round_idx` equals the number of message-word handshakes accepted since the run began, modulo 64.
- R10: `cv_out` changes only in a cycle in which `done` is 1, and otherwise holds the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin compressing one block (accepted only in IDLE) |
| cv_in | input | 256 | Chaining value, word A in bits 255:224 |
| msg_valid | input | 1 | Expander has a word pair for the current round |
| msg_w | input | 32 | Plain message word W_j |
| msg_wp | input | 32 | Mixed message word W'_j |
| msg_ready | output | 1 | Engine accepts a word pair this cycle |
| round_idx | output | 6 | Index of the round awaiting its words |
| busy | output | 1 | A block is being compressed |
| done | output | 1 | One-cycle pulse: `cv_out` holds a new result |
| cv_out | output | 256 | New chaining value, same packing as `cv_in` |

## Verification
The bench drives the "abc" vector and several other blocks against an independent model of the compression. A round constant or boolean function that switched at the wrong index would corrupt every digest. Stalls are injected at round 0, at the 15/16 boundary and at round 63. A counter that advanced without a valid word would drop a round and produce a wrong result, and the stalled-cycle checks on `round_idx` would catch it directly.

One run pulses `start` and rewrites `cv_in` mid-block. A design that restarted, or that folded with the live input instead of the captured value, would report a wrong digest. The `done` cycle and the holding of `cv_out` across the following run are checked cycle by cycle, so an early, late or double pulse is caught.

// File: rtl/sm3c_pkg.sv
package sm3c_pkg;

    localparam int WORD_W       = 32;
    localparam int NWORDS       = 8;
    localparam int STATE_W      = WORD_W * NWORDS;
    localparam int ROUNDS       = 64;
    localparam int CNT_W        = $clog2(ROUNDS);
    localparam int ROT_W        = $clog2(WORD_W);
    localparam int EARLY_ROUNDS = 16;

    localparam logic [WORD_W-1:0] T_EARLY = 32'h79cc4519;
    localparam logic [WORD_W-1:0] T_LATE  = 32'h7a879d8a;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [CNT_W-1:0]  rnd_t;

    typedef struct packed {
        word_t a;
        word_t b;
        word_t c;
        word_t d;
        word_t e;
        word_t f;
        word_t g;
        word_t h;
    } wstate_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ROUND = 2'd1,
        ST_FOLD  = 2'd2
    } phase_e;

    function automatic word_t rol(input word_t x, input int unsigned n);
        return (x << n) | (x >> (WORD_W - n));
    endfunction

    function automatic word_t p0(input word_t x);
        return x ^ rol(x, 9) ^ rol(x, 17);
    endfunction

endpackage

// File: rtl/sm3c_kgen.sv
module sm3c_kgen
    import sm3c_pkg::*;
(
    input  rnd_t  rnd,
    output word_t k,
    output logic  late
);
    word_t base;

    always_comb begin
        late = (rnd >= rnd_t'(EARLY_ROUNDS));
        base = late ? T_LATE : T_EARLY;
        k    = rol(base, int'(rnd[ROT_W-1:0]));
    end
endmodule

// File: rtl/sm3c_round.sv
module sm3c_round
    import sm3c_pkg::*;
(
    input  wstate_t cur,
    input  word_t   w,
    input  word_t   wp,
    input  word_t   k,
    input  logic    late,
    output wstate_t nxt
);
    word_t a12, ss1, ss2, ff, gg, tt1, tt2;

    always_comb begin
        a12 = rol(cur.a, 12);
        ss1 = rol(a12 + cur.e + k, 7);
        ss2 = ss1 ^ a12;
        if (late) begin
            ff = (cur.a & cur.b) | (cur.a & cur.c) | (cur.b & cur.c);
            gg = (cur.e & cur.f) | (~cur.e & cur.g);
        end else begin
            ff = cur.a ^ cur.b ^ cur.c;
            gg = cur.e ^ cur.f ^ cur.g;
        end
        tt1 = ff + cur.d + ss2 + wp;
        tt2 = gg + cur.h + ss1 + w;

        nxt.a = tt1;
        nxt.b = cur.a;
        nxt.c = rol(cur.b, 9);
        nxt.d = cur.c;
        nxt.e = p0(tt2);
        nxt.f = cur.e;
        nxt.g = rol(cur.f, 19);
        nxt.h = cur.g;
    end
endmodule

// File: rtl/sm3c_engine.sv
module sm3c_engine
    import sm3c_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [STATE_W-1:0] cv_in,
    input  logic               msg_valid,
    input  logic [WORD_W-1:0]  msg_w,
    input  logic [WORD_W-1:0]  msg_wp,
    output logic               msg_ready,
    output logic [CNT_W-1:0]   round_idx,
    output logic               busy,
    output logic               done,
    output logic [STATE_W-1:0] cv_out
);
    phase_e  state_q, state_d;
    rnd_t    rnd_q;
    wstate_t work_q, chain_q, round_nxt;
    logic [STATE_W-1:0] work_flat, chain_flat, folded;
    logic [STATE_W-1:0] cv_out_q;
    logic    done_q;
    logic    load, fire, fold, last;
    word_t   k_cur;
    logic    late_cur;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign last = (rnd_q == rnd_t'(ROUNDS - 1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_ROUND;
            ST_ROUND: if (fire && last) state_d = ST_FOLD;
            ST_FOLD:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs and datapath controls
    always_comb begin
        busy      = (state_q != ST_IDLE);
        msg_ready = (state_q == ST_ROUND);
        load      = (state_q == ST_IDLE) && start;
        fire      = (state_q == ST_ROUND) && msg_valid;
        fold      = (state_q == ST_FOLD);
    end

    sm3c_kgen u_kgen (
        .rnd  (rnd_q),
        .k    (k_cur),
        .late (late_cur)
    );

    sm3c_round u_round (
        .cur  (work_q),
        .w    (msg_w),
        .wp   (msg_wp),
        .k    (k_cur),
        .late (late_cur),
        .nxt  (round_nxt)
    );

    assign work_flat  = work_q;
    assign chain_flat = chain_q;

    // per-word feed-forward
    for (genvar i = 0; i < NWORDS; i++) begin : g_fold
        assign folded[i*WORD_W +: WORD_W] =
            work_flat[i*WORD_W +: WORD_W] ^ chain_flat[i*WORD_W +: WORD_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work_q   <= '0;
            chain_q  <= '0;
            rnd_q    <= '0;
            cv_out_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= fold;
            if (load) begin
                work_q  <= cv_in;
                chain_q <= cv_in;
                rnd_q   <= '0;
            end else if (fire) begin
                work_q <= round_nxt;
                rnd_q  <= rnd_q + 1'b1;
            end
            if (fold) cv_out_q <= folded;
        end
    end

    assign done      = done_q;
    assign cv_out    = cv_out_q;
    assign round_idx = rnd_q;
endmodule

// File: rtl/sm3c_engine_chk.sv
module sm3c_engine_chk
    import sm3c_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               msg_valid,
    input logic               msg_ready,
    input logic [CNT_W-1:0]   round_idx,
    input logic               busy,
    input logic               done,
    input logic [STATE_W-1:0] cv_out
);
    // R2
    ready_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_ready |-> busy);

    // R2
    start_enters_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && round_idx == '0));

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3
    done_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R4
    stall_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_ready && !msg_valid) |=> (round_idx == $past(round_idx)));

    // R9
    handshake_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_ready && msg_valid) |=> (round_idx == CNT_W'($past(round_idx) + 1'b1)));

    // R5
    start_busy_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_ready && start && !msg_valid) |=> (busy && round_idx == $past(round_idx)));

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cv_out) |-> done);
endmodule

bind sm3c_engine sm3c_engine_chk u_chk (.*);

// File: tb/sm3c_engine_test.sv
module sm3c_engine_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [255:0] cv_in = '0;
    logic         msg_valid = 1'b0;
    logic [31:0]  msg_w = '0;
    logic [31:0]  msg_wp = '0;
    logic         msg_ready;
    logic [5:0]   round_idx;
    logic         busy;
    logic         done;
    logic [255:0] cv_out;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    logic [255:0] exp_q[$];
    string        tag_q[$];
    logic [255:0] last_exp = '0;
    bit           have_last = 0;

    localparam logic [255:0] IV = 256'h7380166f_4914b2b9_172442d7_da8a0600_a96f30bc_163138aa_e38dee4d_b0fb0e4e;
    localparam logic [255:0] ABC_DIGEST = 256'h66c7f0f4_62eeedd9_d1f2d46b_dc10e4e2_4167c487_5cf2f7a2_297da02b_8f4ba8e0;
    localparam logic [511:0] ABC_BLK = {32'h61626380, {14{32'h0}}, 32'h00000018};

    always #2 clk = ~clk;

    sm3c_engine uut (.*);

    function automatic logic [31:0] rl(input logic [31:0] x, input int n);
        int m = n % 32;
        if (m == 0) return x;
        return (x << m) | (x >> (32 - m));
    endfunction

    function automatic logic [31:0] ref_p1(input logic [31:0] x);
        return x ^ rl(x, 15) ^ rl(x, 23);
    endfunction

    function automatic void expand(input logic [511:0] blk,
                                   output logic [31:0] w[68],
                                   output logic [31:0] wp[64]);
        for (int i = 0; i < 16; i++) w[i] = blk[511 - 32*i -: 32];
        for (int i = 16; i < 68; i++)
            w[i] = ref_p1(w[i-16] ^ w[i-9] ^ rl(w[i-3], 15)) ^ rl(w[i-13], 7) ^ w[i-6];
        for (int i = 0; i < 64; i++) wp[i] = w[i] ^ w[i+4];
    endfunction

    function automatic logic [255:0] model(input logic [255:0] cv, input logic [511:0] blk);
        logic [31:0] w[68];
        logic [31:0] wp[64];
        logic [31:0] v[8];
        logic [31:0] ss1, ss2, tt1, tt2, fv, gv, kk;
        logic [255:0] r;
        expand(blk, w, wp);
        for (int i = 0; i < 8; i++) v[i] = cv[255 - 32*i -: 32];
        for (int j = 0; j < 64; j++) begin
            kk  = rl((j < 16) ? 32'h79cc4519 : 32'h7a879d8a, j);
            ss1 = rl(rl(v[0], 12) + v[4] + kk, 7);
            ss2 = ss1 ^ rl(v[0], 12);
            if (j < 16) begin
                fv = v[0] ^ v[1] ^ v[2];
                gv = v[4] ^ v[5] ^ v[6];
            end else begin
                fv = (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
                gv = (v[4] & v[5]) | (~v[4] & v[6]);
            end
            tt1 = fv + v[3] + ss2 + wp[j];
            tt2 = gv + v[7] + ss1 + w[j];
            v[3] = v[2]; v[2] = rl(v[1], 9); v[1] = v[0]; v[0] = tt1;
            v[7] = v[6]; v[6] = rl(v[5], 19); v[5] = v[4];
            v[4] = tt2 ^ rl(tt2, 9) ^ rl(tt2, 17);
        end
        for (int i = 0; i < 8; i++) r[255 - 32*i -: 32] = v[i] ^ cv[255 - 32*i -: 32];
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: compare each completed result against the scoreboard
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3 unexpected done", cv_out, '0);
            end else begin
                logic [255:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(cv_out === e, t, cv_out, e);
            end
        end
    end

    // mode 0: no stalls, 1: periodic stalls, 2: stalls at round 0/15/16/63,
    // 3: start pulse and cv_in rewrite mid-run
    task automatic run_block(input logic [255:0] cv, input logic [511:0] blk,
                             input logic [255:0] exp, input string tag, input int mode);
        logic [31:0] w[68];
        logic [31:0] wp[64];
        expand(blk, w, wp);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        cv_in = cv;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1 && msg_ready === 1'b1 && round_idx === 6'd0, "R2 run entry",
            {busy, msg_ready, round_idx}, {1'b1, 1'b1, 6'd0});
        for (int j = 0; j < 64; j++) begin
            int stall;
            stall = 0;
            if (mode == 1 && (j % 3) == 1) stall = 2;
            if (mode == 2 && (j == 0 || j == 15 || j == 16 || j == 63)) stall = 3;
            for (int s = 0; s < stall; s++) begin
                msg_valid = 1'b0;
                msg_w = 32'hdead_beef;
                msg_wp = 32'h1234_5678;
                @(negedge clk);
                chk(round_idx === 6'(j) && busy === 1'b1, "R4 stall", round_idx, 6'(j));
            end
            if (j == 32 && have_last)
                chk(cv_out === last_exp, "R10 hold during run", cv_out, last_exp);
            msg_valid = 1'b1;
            msg_w = w[j];
            msg_wp = wp[j];
            if (mode == 3 && j == 10) begin
                start = 1'b1;
                cv_in = ~cv;
            end
            @(negedge clk);
            start = 1'b0;
            if (j < 63)
                chk(round_idx === 6'(j + 1), "R9 count", round_idx, 6'(j + 1));
        end
        msg_valid = 1'b0;
        chk(done === 1'b0 && busy === 1'b1, "R3 not early", {done, busy}, 2'b01);
        @(negedge clk);
        chk(done === 1'b1 && busy === 1'b0, "R3 pulse", {done, busy}, 2'b10);
        @(negedge clk);
        chk(done === 1'b0, "R3 single", done, 1'b0);
        last_exp = exp;
        have_last = 1;
        repeat (3) @(negedge clk);
        chk(cv_out === exp, "R10 hold idle", cv_out, exp);
    endtask

    initial begin
        #400000;
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [511:0] blk2;
        logic [511:0] ones;
        logic [255:0] e2, e3;
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0 && msg_ready === 1'b0 && cv_out === '0,
            "R1 during reset", {busy, done, msg_ready}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0 && msg_ready === 1'b0 && cv_out === '0,
            "R1 after reset", cv_out, '0);

        // bench model sanity against the known vector
        chk(model(IV, ABC_BLK) === ABC_DIGEST, "R7 model", model(IV, ABC_BLK), ABC_DIGEST);

        run_block(IV, ABC_BLK, ABC_DIGEST, "R6 abc digest", 0);

        blk2 = '0;
        for (int i = 0; i < 16; i++) blk2[511 - 32*i -: 32] = 32'h9e3779b9 * (i + 1) ^ 32'h0badf00d;
        e2 = model(ABC_DIGEST, blk2);
        run_block(ABC_DIGEST, blk2, e2, "R7 second block periodic stalls", 1);

        ones = '1;
        e3 = model('1, ones);
        run_block('1, ones, e3, "R7 all-ones boundary stalls", 2);

        run_block(IV, ABC_BLK, ABC_DIGEST, "R5 R8 start and cv_in changed mid-run", 3);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R3 missing done", exp_q.size(), 0);
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule